// File: doc/BRIEF.md
# Flash Wait-State Access Controller

This block sits between a bus master and the read port of a nonvolatile memory. It inserts either zero or one wait state on every memory read, chosen by a one-bit latency setting. Software changes the setting through a small register port. A new setting is never applied under a read that is in progress: it is held as pending until the memory side is idle, and then it becomes active. A read of the setting while a change is pending stalls the master until the change has taken effect. Software therefore changes the latency with a write followed by a readback, and can be sure the readback returns only once the memory really runs at the new timing.

The master read port uses valid/ready. A request on `rd_valid` is taken on a clock edge where `rd_ready` is high. The address must stay stable while `rd_valid` is high and `rd_ready` is low. `rd_ready` depends only on internal state, never on `rd_valid`. The response is a one-cycle `rsp_valid` pulse with no back-pressure, and the master must take it in that cycle. The register port uses the same handshake with `cfg_valid`/`cfg_ready`. Writes are always taken in the cycle they are presented. Reads are held off with `cfg_ready` low while a change is pending. On the memory side, `mem_en` pulses for one cycle with `mem_addr`, and the controller samples `mem_rdata` one or two cycles later.

Top module: `flash_ws_ctrl`

## Requirements
- R1: After the synchronous active-low reset the active latency is 0 (zero wait states), nothing is pending, `rd_ready` is high, `rsp_valid` is low, and a register read completes at once returning 0.
- R2: With active latency 0, a read taken at an edge gives `rsp_valid` in the very next cycle, and `rsp_data` equals the memory word at the requested address.
- R3: With active latency 1, a read taken at an edge gives `rsp_valid` low in the next cycle and high in the cycle after, with the memory word at the requested address.
- R4: A new latency written while a read is in flight does not affect that read: the read keeps the old wait-state count. The active setting changes only at an edge where no read was in flight.
- R5: While a latency change is pending, `rd_ready` is low.
- R6: A register read (cfg_write = 0) presented while a change is pending keeps `cfg_ready` low until the change is applied. It then completes with `cfg_rdata` holding the newly active latency in bit 0.
- R7: Writing a value equal to the active latency leaves nothing pending: `rd_ready` stays high and a following register read completes without stall.
- R8: A later write replaces a pending value, and only the last written value ends up active. If the last write restores the active value, the pending change is cancelled.
- R9: A register write (cfg_write = 1, value in `cfg_wdata` bit 0) is always taken in the cycle it is presented (`cfg_ready` high).
- R10: Reads can be issued back to back. Latency 0 sustains one accepted read per cycle, and latency 1 sustains one read every two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_valid | input | 1 | Master read request valid |
| rd_ready | output | 1 | Controller can take a read this cycle |
| rd_addr | input | ADDR_W | Master read address |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_data | output | DATA_W | Read data |
| cfg_valid | input | 1 | Register access valid |
| cfg_write | input | 1 | 1 = write latency, 0 = read latency |
| cfg_wdata | input | LAT_W | Latency value to write |
| cfg_ready | output | 1 | Register access completes this cycle |
| cfg_rdata | output | LAT_W | Active latency value |
| mem_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
Two events can land on the same edge. The first is a register write arriving in the very cycle that a pending change is applied. The bench provokes it by writing during a read, staying idle until the read drains, and then writing again in the first idle cycle. It judges the result by whether the last written value ends up active, using the stall and value of a readback and the latency of a following memory read. The second is a response completing while the next read is accepted. The bench provokes it by holding `rd_valid` high for eight cycles at each latency, and judges it by counting accepted requests against response pulses.

// File: rtl/fws_pkg.sv
package fws_pkg;

  typedef enum logic {
    CFG_READ  = 1'b0,
    CFG_WRITE = 1'b1
  } cfg_op_e;

  // Down-counter width able to hold the largest latency plus one
  function automatic int unsigned cnt_width(input int unsigned lat_w);
    return lat_w + 1;
  endfunction

endpackage

// File: rtl/fws_lat_reg.sv
module fws_lat_reg
  import fws_pkg::*;
#(
  parameter int LAT_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  cfg_op_e          cfg_op,
  input  logic [LAT_W-1:0] cfg_wdata,
  input  logic             rd_inflight,
  output logic             cfg_ready,
  output logic [LAT_W-1:0] cfg_rdata,
  output logic [LAT_W-1:0] lat_active,
  output logic             chg_pending
);

  logic [LAT_W-1:0] act_q;
  logic [LAT_W-1:0] pend_q;
  logic             pend_flag_q;
  logic             wr_fire;
  logic             apply;
  logic [LAT_W-1:0] act_nxt;

  assign wr_fire = cfg_valid && (cfg_op == CFG_WRITE);
  assign apply   = pend_flag_q && !rd_inflight;
  assign act_nxt = apply ? pend_q : act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q       <= '0;
      pend_q      <= '0;
      pend_flag_q <= 1'b0;
    end else begin
      act_q <= act_nxt;
      if (wr_fire) begin
        pend_q      <= cfg_wdata;
        pend_flag_q <= (cfg_wdata != act_nxt);
      end else if (apply) begin
        pend_flag_q <= 1'b0;
      end
    end
  end

  assign cfg_ready   = (cfg_op == CFG_WRITE) || !pend_flag_q;
  assign cfg_rdata   = act_q;
  assign lat_active  = act_q;
  assign chg_pending = pend_flag_q;

  // R4
  latency_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != $past(act_q)) |-> !$past(rd_inflight));

  // R7
  same_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !pend_flag_q && (cfg_wdata == act_q)) |=> !pend_flag_q);

  // R8
  pending_differs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_flag_q |-> (pend_q != act_q));

endmodule

// File: rtl/fws_rd_seq.sv
module fws_rd_seq
  import fws_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LAT_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              hold,
  input  logic [LAT_W-1:0]  lat,
  output logic              mem_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rd_inflight
);

  localparam int CNT_W = cnt_width(LAT_W);

  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  // A new read may start in the last cycle of the previous one
  assign rd_ready = !hold && (cnt_q <= CNT_W'(1));
  assign accept   = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (accept) begin
      cnt_q <= CNT_W'(lat) + CNT_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign rsp_valid   = (cnt_q == CNT_W'(1));
  assign rsp_data    = mem_rdata;
  assign mem_en      = accept;
  assign mem_addr    = rd_addr;
  assign rd_inflight = (cnt_q != '0);

  // R2
  fast_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (lat == '0)) |=> rsp_valid);

  // R3
  slow_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (lat == LAT_W'(1))) |=> (!rsp_valid ##1 rsp_valid));

endmodule

// File: rtl/flash_ws_ctrl.sv
module flash_ws_ctrl
  import fws_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LAT_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              cfg_valid,
  input  logic              cfg_write,
  input  logic [LAT_W-1:0]  cfg_wdata,
  output logic              cfg_ready,
  output logic [LAT_W-1:0]  cfg_rdata,
  output logic              mem_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic [LAT_W-1:0] lat_active;
  logic             chg_pending;
  logic             rd_inflight;
  cfg_op_e          cfg_op;

  assign cfg_op = cfg_op_e'(cfg_write);

  fws_lat_reg #(
    .LAT_W(LAT_W)
  ) u_lat (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_valid  (cfg_valid),
    .cfg_op     (cfg_op),
    .cfg_wdata  (cfg_wdata),
    .rd_inflight(rd_inflight),
    .cfg_ready  (cfg_ready),
    .cfg_rdata  (cfg_rdata),
    .lat_active (lat_active),
    .chg_pending(chg_pending)
  );

  fws_rd_seq #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LAT_W (LAT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_addr    (rd_addr),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .hold       (chg_pending),
    .lat        (lat_active),
    .mem_en     (mem_en),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .rd_inflight(rd_inflight)
  );

  // R5
  pending_blocks_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_pending |-> !rd_ready);

  // R6
  cfg_read_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_write && cfg_ready) |-> !rd_inflight || !chg_pending);

endmodule

// File: tb/flash_ws_ctrl_tb.sv
module flash_ws_ctrl_tb_top;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int LW = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_valid = 1'b0;
  logic          rd_ready;
  logic [AW-1:0] rd_addr = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          cfg_valid = 1'b0;
  logic          cfg_write = 1'b0;
  logic [LW-1:0] cfg_wdata = '0;
  logic          cfg_ready;
  logic [LW-1:0] cfg_rdata;
  logic          mem_en;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_q = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_ws_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LAT_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_wdata(cfg_wdata),
    .cfg_ready(cfg_ready), .cfg_rdata(cfg_rdata),
    .mem_en(mem_en), .mem_addr(mem_addr), .mem_rdata(mem_q)
  );

  function automatic logic [DW-1:0] mem_f(input logic [AW-1:0] a);
    return DW'(32'(a) * 37 + 11);
  endfunction

  always_ff @(posedge clk) if (mem_en) mem_q <= mem_f(mem_addr);

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mem_read(input int a, input int exp_lat, input string req);
    int n;
    rd_valid = 1'b1;
    rd_addr  = AW'(a);
    while (!rd_ready) @(negedge clk);
    @(negedge clk);
    rd_valid = 1'b0;
    n = 1;
    while (!rsp_valid && n < 8) begin
      @(negedge clk);
      n++;
    end
    check_eq({req, " rsp cycle"}, n, exp_lat + 1);
    check_eq({req, " rsp data"}, rsp_data, mem_f(AW'(a)));
  endtask

  task automatic stream(input int exp_acc, input string req);
    int acc = 0;
    int rsp = 0;
    rd_valid = 1'b1;
    for (int k = 0; k < 8; k++) begin
      rd_addr = AW'(k);
      if (rd_ready) acc++;
      @(negedge clk);
      if (rsp_valid) rsp++;
    end
    rd_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (rsp_valid) rsp++;
    end
    check_eq({req, " accepted"}, acc, exp_acc);
    check_eq({req, " responses"}, rsp, exp_acc);
  endtask

  task automatic cfg_wr(input int v, input string req);
    cfg_valid = 1'b1;
    cfg_write = 1'b1;
    cfg_wdata = LW'(v);
    #1;
    check_eq({req, " R9 write ready"}, cfg_ready, 1);
    @(negedge clk);
    cfg_valid = 1'b0;
    cfg_write = 1'b0;
  endtask

  task automatic cfg_rd(input int exp_v, input int exp_stall, input string req);
    int n = 0;
    cfg_valid = 1'b1;
    cfg_write = 1'b0;
    #1;
    while (!cfg_ready && n < 30) begin
      check_eq({req, " R5 no read while pending"}, rd_ready, 0);
      @(negedge clk);
      #1;
      n++;
    end
    if (exp_stall >= 0) check_eq({req, " stall"}, n, exp_stall);
    check_eq({req, " value"}, cfg_rdata, exp_v);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_eq("R1 rd_ready", rd_ready, 1);
    check_eq("R1 rsp_valid", rsp_valid, 0);
    cfg_rd(0, 0, "R1");

    // R2 sweep of every address at zero wait states
    for (int a = 0; a < (1 << AW); a++) mem_read(a, 0, "R2");
    stream(8, "R10 lat0");

    // R6 idle change: one stall cycle, new value returned
    cfg_wr(1, "R6");
    cfg_rd(1, 1, "R6");

    // R3 sweep at one wait state
    for (int a = 0; a < (1 << AW); a++) mem_read(a, 1, "R3");
    stream(4, "R10 lat1");

    // R4 write during an in-flight read; R5 reads held; R6 stall of two
    rd_valid = 1'b1;
    rd_addr  = AW'(5);
    check_eq("R4 ready", rd_ready, 1);
    @(negedge clk);
    rd_valid  = 1'b0;
    cfg_valid = 1'b1;
    cfg_write = 1'b1;
    cfg_wdata = 1'b0;
    check_eq("R4 no early rsp", rsp_valid, 0);
    @(negedge clk);
    check_eq("R4 old latency rsp", rsp_valid, 1);
    check_eq("R4 old latency data", rsp_data, mem_f(AW'(5)));
    cfg_rd(0, 2, "R6 after flight");
    mem_read(9, 0, "R4 new latency");

    // R7 same-value write
    cfg_wr(0, "R7");
    check_eq("R7 rd_ready", rd_ready, 1);
    cfg_rd(0, 0, "R7");
    mem_read(2, 0, "R7");

    // R8 second write cancels the pending one
    cfg_wr(1, "R8 setup");
    cfg_rd(1, 1, "R8 setup");
    rd_valid = 1'b1;
    rd_addr  = AW'(3);
    check_eq("R8 ready", rd_ready, 1);
    @(negedge clk);
    rd_valid  = 1'b0;
    cfg_valid = 1'b1;
    cfg_write = 1'b1;
    cfg_wdata = 1'b0;
    @(negedge clk);
    cfg_wdata = 1'b1;
    check_eq("R4 rsp under pending", rsp_valid, 1);
    check_eq("R4 data under pending", rsp_data, mem_f(AW'(3)));
    @(negedge clk);
    cfg_valid = 1'b0;
    cfg_write = 1'b0;
    check_eq("R8 cancelled rd_ready", rd_ready, 1);
    cfg_rd(1, 0, "R8");
    mem_read(6, 1, "R8");

    // R8 coincident: write lands in the cycle the pending change applies
    rd_valid = 1'b1;
    rd_addr  = AW'(7);
    check_eq("R8 coincident ready", rd_ready, 1);
    @(negedge clk);
    rd_valid  = 1'b0;
    cfg_valid = 1'b1;
    cfg_write = 1'b1;
    cfg_wdata = 1'b0;
    @(negedge clk);
    cfg_valid = 1'b0;
    cfg_write = 1'b0;
    @(negedge clk);
    cfg_valid = 1'b1;
    cfg_write = 1'b1;
    cfg_wdata = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
    cfg_write = 1'b0;
    cfg_rd(1, -1, "R8 coincident");
    mem_read(12, 1, "R8 coincident");

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule